// File: doc/BRIEF.md
# Fixed-Weight Threshold Network

This block computes a small boolean function with a two-layer feed-forward network of hard-limit neurons instead of ordinary gates. Each neuron forms an integer net: the weighted sum of its binary inputs plus a bias. It fires (outputs 1) when that net is zero or positive. A hidden layer of three neurons reads the primary inputs. One output neuron reads the three hidden outputs. All weights and biases are constants fixed at elaboration.

Each weight lies in the range -3 to +3. It is held as a 3-bit sign-magnitude code: bit 2 is the sign (1 means negative) and bits 1:0 are the magnitude. Multiplying a weight by a binary input therefore reduces to ANDing that input with the magnitude bits. The sign bit then chooses whether the product is added to the net or subtracted from it.

The parameter `CFG` selects one of two built-in networks:
- `CFG=0`: a 4-input network.
- `CFG=1`: a 3-input network.

Both layers are registered behind a synchronous active-high reset. The hidden firing pattern appears one cycle after the inputs are sampled, and the network result two cycles after. A new input pattern may be applied every cycle.

Top module: `ttn_net`

## Requirements
- R1: While `rst` is high at a rising clock edge, `h_o` and `y_o` become 0 at that edge. The reset is synchronous, so a reset raised during operation takes effect at the next edge.
- R2: `h_o` shows the hidden firing pattern for the input sampled at the previous edge. `y_o` shows the network result for the input sampled two edges earlier. The block accepts a new pattern on every cycle.
- R3: With `CFG=0`, bit n of `h_o` is hidden neuron n. The weight rows for neurons 0, 1 and 2 are (2, 2, 1, -1), (2, 1, -1, 0) and (-1, 1, 2, -1). Their biases are -3, -1 and -2.
- R4: With `CFG=0`, the output neuron weighs hidden bits 0, 1 and 2 by 2, -2 and -2, with bias +1. An all-zero input therefore gives `y_o`=1.
- R5: With `CFG=1`, the hidden weight rows for neurons 0, 1 and 2 are (-2, 1, -2), (0, 2, 1) and (-2, -2, -2). Their biases are +1, -2 and +3.
- R6: With `CFG=1`, the output neuron weighs hidden bits 0, 1 and 2 by -1, +1 and +1, with bias -1. An all-zero input therefore gives `y_o`=0.
- R7: Every neuron fires when its net is exactly zero. It is silent only when the net is negative.
- R8: Input bit `x_i[i]` is multiplied by the weight in position i of each row, where position 0 is the first listed weight.
- R9: While `x_i` holds one value, `h_o` stays constant from the second edge onward and `y_o` from the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| x_i | input | NIN (4 for CFG=0, 3 for CFG=1) | Binary input pattern |
| h_o | output | 3 | Registered hidden-layer firing pattern |
| y_o | output | 1 | Registered network result |

## Verification
On every cycle, the assertions check four things:
- the reset clearing of both layers;
- that no output is unknown;
- that held inputs give stable outputs;
- the known result for an all-zero input in each configuration, two cycles after it is applied.

The exact truth table of each configuration, including the patterns whose net lands exactly on zero, can only be shown by the bench. It applies every input pattern to both configurations, both one at a time and back-to-back, and compares the outputs with a model built from the weight tables.

// File: rtl/ttn_pkg.sv
package ttn_pkg;
  localparam int MAXIN = 4;
  localparam int NHID  = 3;

  // Sign-magnitude weight code: [2]=negative, [1:0]=magnitude
  typedef logic [2:0] smw_t;

  function automatic int num_in(input int cfg);
    return (cfg == 0) ? 4 : 3;
  endfunction

  function automatic smw_t to_sm(input int v);
    smw_t s;
    s[2]   = (v < 0);
    s[1:0] = 2'((v < 0) ? -v : v);
    return s;
  endfunction

  function automatic int weight(input int cfg, input int layer, input int n, input int i);
    int r [4];
    r = '{0, 0, 0, 0};
    if (cfg == 0 && layer == 0) begin
      case (n)
        0:       r = '{2, 2, 1, -1};
        1:       r = '{2, 1, -1, 0};
        default: r = '{-1, 1, 2, -1};
      endcase
    end else if (cfg == 0) begin
      r = '{2, -2, -2, 0};
    end else if (layer == 0) begin
      case (n)
        0:       r = '{-2, 1, -2, 0};
        1:       r = '{0, 2, 1, 0};
        default: r = '{-2, -2, -2, 0};
      endcase
    end else begin
      r = '{-1, 1, 1, 0};
    end
    return r[i[1:0]];
  endfunction

  function automatic int bias(input int cfg, input int layer, input int n);
    int b;
    if (cfg == 0) b = (layer != 0) ? 1 : (n == 0) ? -3 : (n == 1) ? -1 : -2;
    else          b = (layer != 0) ? -1 : (n == 0) ? 1 : (n == 1) ? -2 : 3;
    return b;
  endfunction

  function automatic logic [MAXIN*3-1:0] row_vec(input int cfg, input int layer, input int n);
    logic [MAXIN*3-1:0] v;
    v = '0;
    for (int i = 0; i < MAXIN; i++) v[3*i +: 3] = to_sm(weight(cfg, layer, n, i));
    return v;
  endfunction
endpackage

// File: rtl/ttn_neuron.sv
module ttn_neuron #(
  parameter int NIN = 4,
  parameter logic [NIN*3-1:0] WV = '0,
  parameter int BIAS = 0
) (
  input  logic [NIN-1:0] a_i,
  output logic           fire_o
);
  int acc;
  logic [1:0] prod;

  always_comb begin
    acc  = BIAS;
    prod = '0;
    for (int i = 0; i < NIN; i++) begin
      prod = {2{a_i[i]}} & WV[3*i +: 2];
      acc  = WV[3*i+2] ? acc - int'(prod) : acc + int'(prod);
    end
    fire_o = (acc >= 0);
  end
endmodule

// File: rtl/ttn_layer.sv
module ttn_layer #(
  parameter int CFG   = 0,
  parameter int LAYER = 0,
  parameter int NIN   = 4,
  parameter int NOUT  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NIN-1:0]  a_i,
  output logic [NOUT-1:0] q_o
);
  logic [NOUT-1:0] fire;

  for (genvar n = 0; n < NOUT; n++) begin : g_neuron
    localparam logic [ttn_pkg::MAXIN*3-1:0] FULL = ttn_pkg::row_vec(CFG, LAYER, n);
    ttn_neuron #(
      .NIN (NIN),
      .WV  (FULL[NIN*3-1:0]),
      .BIAS(ttn_pkg::bias(CFG, LAYER, n))
    ) u_neuron (
      .a_i   (a_i),
      .fire_o(fire[n])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= fire;
  end
endmodule

// File: rtl/ttn_net.sv
module ttn_net #(
  parameter  int CFG = 0,
  localparam int NIN = ttn_pkg::num_in(CFG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NIN-1:0] x_i,
  output logic [2:0]     h_o,
  output logic           y_o
);
  localparam int NH = ttn_pkg::NHID;
  logic [NH-1:0] hid;
  logic [0:0]    res;

  ttn_layer #(.CFG(CFG), .LAYER(0), .NIN(NIN), .NOUT(NH)) u_hidden (
    .clk(clk), .rst(rst), .a_i(x_i), .q_o(hid)
  );

  ttn_layer #(.CFG(CFG), .LAYER(1), .NIN(NH), .NOUT(1)) u_output (
    .clk(clk), .rst(rst), .a_i(hid), .q_o(res)
  );

  assign h_o = hid;
  assign y_o = res[0];
endmodule

// File: rtl/ttn_net_chk.sv
module ttn_net_chk #(
  parameter int CFG = 0,
  parameter int NIN = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [NIN-1:0] x_i,
  input logic [2:0]     h_o,
  input logic           y_o
);
  logic [2:0] age;

  always_ff @(posedge clk) begin
    if (rst)           age <= '0;
    else if (age != 7) age <= age + 3'd1;
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (h_o == 3'b000 && y_o == 1'b0));

  assert_known_R1: assert property (@(posedge clk) disable iff (rst)
    (age >= 1) |-> !$isunknown({h_o, y_o}));

  assert_hold_hidden_R9: assert property (@(posedge clk) disable iff (rst)
    (age >= 3 && $past(x_i, 1) == $past(x_i, 2)) |-> $stable(h_o));

  assert_hold_result_R9: assert property (@(posedge clk) disable iff (rst)
    (age >= 4 && $past(x_i, 2) == $past(x_i, 3)) |-> $stable(y_o));

  if (CFG == 0) begin : g_cfg0
    assert_zero_input_R4: assert property (@(posedge clk) disable iff (rst)
      (age >= 3 && $past(x_i, 2) == '0) |-> y_o);
  end else begin : g_cfg1
    assert_zero_input_R6: assert property (@(posedge clk) disable iff (rst)
      (age >= 3 && $past(x_i, 2) == '0) |-> !y_o);
  end
endmodule

bind ttn_net ttn_net_chk #(.CFG(CFG), .NIN(NIN)) u_chk (
  .clk(clk), .rst(rst), .x_i(x_i), .h_o(h_o), .y_o(y_o)
);

// File: tb/ttn_net_tb.sv
module ttn_net_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] xa  = '0;
  logic [2:0] xb  = '0;
  logic [2:0] ha, hb;
  logic       ya, yb;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ttn_net #(.CFG(0)) u_dut  (.clk(clk), .rst(rst), .x_i(xa), .h_o(ha), .y_o(ya));
  ttn_net #(.CFG(1)) u_dut3 (.clk(clk), .rst(rst), .x_i(xb), .h_o(hb), .y_o(yb));

  // Reference weight tables taken from R3..R6
  function automatic int rw(int cfg, int layer, int n, int i);
    int t [4];
    if (cfg == 0 && layer == 0)
      t = (n == 0) ? '{2, 2, 1, -1} : (n == 1) ? '{2, 1, -1, 0} : '{-1, 1, 2, -1};
    else if (cfg == 0) t = '{2, -2, -2, 0};
    else if (layer == 0)
      t = (n == 0) ? '{-2, 1, -2, 0} : (n == 1) ? '{0, 2, 1, 0} : '{-2, -2, -2, 0};
    else t = '{-1, 1, 1, 0};
    return t[i];
  endfunction

  function automatic int rb(int cfg, int layer, int n);
    int b0 [3];
    if (layer == 1) return (cfg == 0) ? 1 : -1;
    b0 = (cfg == 0) ? '{-3, -1, -2} : '{1, -2, 3};
    return b0[n];
  endfunction

  function automatic int hnet(int cfg, int x, int n);
    int s = rb(cfg, 0, n);
    for (int i = 0; i < 4; i++) s += ((x >> i) & 1) * rw(cfg, 0, n, i);  // R8 bit order
    return s;
  endfunction

  function automatic logic [2:0] ref_h(int cfg, int x);
    logic [2:0] h;
    for (int n = 0; n < 3; n++) h[n] = (hnet(cfg, x, n) >= 0);
    return h;
  endfunction

  function automatic logic ref_y(int cfg, int x);
    logic [2:0] h = ref_h(cfg, x);
    int s = rb(cfg, 1, 0);
    for (int n = 0; n < 3; n++) s += int'(h[n]) * rw(cfg, 1, 0, n);
    return (s >= 0);
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic t_reset_R1();
    rst = 1'b1; xa = 4'hF; xb = 3'h7;
    repeat (3) @(negedge clk);
    chk("R1 reset h cfg0", ha, 0); chk("R1 reset y cfg0", ya, 0);
    chk("R1 reset h cfg1", hb, 0); chk("R1 reset y cfg1", yb, 0);
    rst = 1'b0;
  endtask

  task automatic t_exhaustive();
    for (int x = 0; x < 16; x++) begin
      xa = 4'(x); xb = 3'(x);
      @(negedge clk);
      chk($sformatf("R3/R8 cfg0 hidden x=%0d", x), ha, ref_h(0, x));
      if (x < 8) chk($sformatf("R5/R8 cfg1 hidden x=%0d", x), hb, ref_h(1, x));
      @(negedge clk);
      chk($sformatf("R4 cfg0 result x=%0d", x), ya, ref_y(0, x));
      if (x < 8) chk($sformatf("R6 cfg1 result x=%0d", x), yb, ref_y(1, x));
    end
  endtask

  task automatic t_zero_net_R7();
    for (int cfg = 0; cfg < 2; cfg++)
      for (int x = 0; x < (cfg == 0 ? 16 : 8); x++)
        for (int n = 0; n < 3; n++)
          if (hnet(cfg, x, n) == 0) begin
            if (cfg == 0) xa = 4'(x); else xb = 3'(x);
            @(negedge clk);
            chk($sformatf("R7 net=0 fires cfg%0d x=%0d n=%0d", cfg, x, n),
                cfg == 0 ? int'(ha[n]) : int'(hb[n]), 1);
          end
  endtask

  task automatic t_stream_R2();
    for (int k = 0; k < 18; k++) begin
      if (k >= 1) chk("R2 hidden latency", ha, ref_h(0, (k - 1) % 16));
      if (k >= 2) chk("R2 result latency", ya, ref_y(0, (k - 2) % 16));
      xa = 4'(k % 16);
      @(negedge clk);
    end
  endtask

  task automatic t_hold_R9();
    xa = 4'd13; xb = 3'd5;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      chk("R9 hold y cfg0", ya, ref_y(0, 13));
      chk("R9 hold y cfg1", yb, ref_y(1, 5));
      @(negedge clk);
    end
  endtask

  task automatic t_midreset_R1();
    xa = 4'd0; xb = 3'd0;
    repeat (3) @(negedge clk);
    chk("R4 zero input result", ya, 1);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 sync reset y cfg0", ya, 0);
    chk("R1 sync reset h cfg1", hb, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 zero input result", yb, 0);
  endtask

  initial begin
    t_reset_R1();
    t_exhaustive();
    t_zero_net_R7();
    t_stream_R2();
    t_hold_R9();
    t_midreset_R1();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule